// File: doc/BRIEF.md
# Free-Running Counter Timer with Periodic Comparator

This block is a timer peripheral built around one 64-bit up-counter that never stops once software sets its run bit. Software reaches the block through a plain 32-bit register port: an address, write data, a write strobe, and read data that is driven combinationally from the addressed register. The counter can be preset one 32-bit half at a time. It is read back the same way.

A single 64-bit comparator watches the counter. When the comparator is enabled and the counter equals the compare value, an interrupt status flag is set. The interrupt line is that flag gated by an enable bit. If the auto-increment option is on, every match adds a programmed 32-bit step to the compare value, so one setup yields an event train at a fixed spacing. With the option off, a match fires once.

Each write to a counter half, a compare half, the step register or the control register is acknowledged by a sticky status bit. Software polls this bit and clears it by writing 1 to it.

Top module: `frt_timer_top`

## Requirements
- R1: After reset every mapped register reads zero and `irq_o` is low.
- R2: While control bit 8 (run) at 0x240 is 1, the 64-bit counter rises by one per clock and carries from the low half into the high half. The low half reads at 0x100 and the high half at 0x104.
- R3: A write to 0x100 replaces only the low half, and a write to 0x104 replaces only the high half. In the cycle of that write the counter does not also increment. Counting resumes from the written value on the following clock.
- R4: Register 0x110 holds the counter write flags: bit 0 for a 0x100 write and bit 1 for a 0x104 write. A flag becomes visible one clock after the write takes effect and stays set until software writes 1 to that bit. If a set and a clear reach a flag on the same edge, the flag stays set.
- R5: Register 0x24C holds the comparator-side write flags: bit 0 for 0x200, bit 1 for 0x204, bit 2 for 0x208 and bit 16 for 0x240. These flags have the same timing and the same clear rule as in R4.
- R6: When control bit 0 (compare enable) is 1 and the counter equals the 64-bit compare value ({0x204, 0x200}), bit 0 of 0x244 is set on that edge. Writing 1 to that bit clears it. A match on the same edge wins over the clear.
- R7: `irq_o` equals bit 0 of 0x244 AND bit 0 of 0x248.
- R8: With control bit 1 (auto-increment) at 0, a match leaves the compare value unchanged, so only one event occurs.
- R9: With control bit 1 at 1, each match adds the zero-extended 32-bit step at 0x208 to the compare value, which produces matches at a fixed spacing.
- R10: A software write to a compare half on the same edge as an auto-increment match takes precedence, and that increment is discarded.
- R11: Control reads back bits 8, 1 and 0 as written, with every other bit zero. Any unmapped address reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 12 | Register byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_we_i | input | 1 | Write strobe; one write per clock |
| bus_rdata_o | output | 32 | Read data of the addressed register |
| irq_o | output | 1 | Comparator interrupt |

## Verification
The bench targets the carry from the low counter half into the high half. A design that dropped this carry would show the high half stuck after 0xFFFFFFFF. It writes one counter half while the counter runs: a design that also incremented in the write cycle, or that disturbed the other half, would read off by one or corrupt the untouched half. It lands a write-status clear on the same edge as a new set, which a design with the wrong priority would lose, and it lands a compare write on the exact edge of an auto-increment match, where a design with the wrong priority would keep the summed value. One-shot and periodic modes both run long enough to catch a comparator that rearms when it should not, or one that fails to rearm. Masked and unmasked interrupts are compared cycle by cycle against the status flag.

// File: rtl/frt_pkg.sv
package frt_pkg;

    // register byte offsets
    localparam int unsigned OFF_CNT_LO  = 'h100;
    localparam int unsigned OFF_CNT_HI  = 'h104;
    localparam int unsigned OFF_CNT_WS  = 'h110;
    localparam int unsigned OFF_CMP_LO  = 'h200;
    localparam int unsigned OFF_CMP_HI  = 'h204;
    localparam int unsigned OFF_STEP    = 'h208;
    localparam int unsigned OFF_CTRL    = 'h240;
    localparam int unsigned OFF_IRQ_ST  = 'h244;
    localparam int unsigned OFF_IRQ_EN  = 'h248;
    localparam int unsigned OFF_CMP_WS  = 'h24C;

    // control field positions
    localparam int unsigned CTRL_RUN_BIT  = 8;
    localparam int unsigned CTRL_AINC_BIT = 1;
    localparam int unsigned CTRL_CEN_BIT  = 0;

    // comparator-side write flag: bit position in the status word per source
    localparam int unsigned CWS_NUM      = 4;
    localparam int unsigned CWS_IDX_LO   = 0;
    localparam int unsigned CWS_IDX_HI   = 1;
    localparam int unsigned CWS_IDX_STEP = 2;
    localparam int unsigned CWS_IDX_CTRL = 3;
    localparam int unsigned CWS_CTRL_POS = 16;

    // counter-side write flags
    localparam int unsigned KWS_NUM = 2;

    typedef struct packed {
        logic run;
        logic ainc;
        logic cmp_en;
        logic irq_st;
        logic irq_en;
    } top_state_t;

endpackage

// File: rtl/frt_counter.sv
module frt_counter #(
    parameter int unsigned HALF_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run_i,
    input  logic                  wr_lo_i,
    input  logic                  wr_hi_i,
    input  logic [HALF_W-1:0]     wdata_i,
    output logic [2*HALF_W-1:0]   count_o
);
    localparam int unsigned CNT_W = 2 * HALF_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (wr_lo_i || wr_hi_i) begin
            if (wr_lo_i) s_d.cnt[HALF_W-1:0]     = wdata_i;
            if (wr_hi_i) s_d.cnt[CNT_W-1:HALF_W] = wdata_i;
        end else if (run_i) begin
            s_d.cnt = s_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count_o = s_q.cnt;

    AST_COUNT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !wr_lo_i && !wr_hi_i) |=> (count_o == $past(count_o) + CNT_W'(1))); // R2

    AST_COUNT_LO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo_i |=> (count_o[HALF_W-1:0] == $past(wdata_i)
                     && count_o[CNT_W-1:HALF_W] == $past(count_o[CNT_W-1:HALF_W]))); // R3

    AST_COUNT_HI_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi_i |=> (count_o[CNT_W-1:HALF_W] == $past(wdata_i)
                     && count_o[HALF_W-1:0] == $past(count_o[HALF_W-1:0]))); // R3

endmodule

// File: rtl/frt_comparator.sv
module frt_comparator #(
    parameter int unsigned HALF_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*HALF_W-1:0]   count_i,
    input  logic                  cmp_en_i,
    input  logic                  auto_inc_i,
    input  logic                  wr_lo_i,
    input  logic                  wr_hi_i,
    input  logic                  wr_step_i,
    input  logic [HALF_W-1:0]     wdata_i,
    output logic [2*HALF_W-1:0]   cmp_o,
    output logic [HALF_W-1:0]     step_o,
    output logic                  match_o
);
    localparam int unsigned CNT_W = 2 * HALF_W;

    typedef struct packed {
        logic [CNT_W-1:0]  cmp;
        logic [HALF_W-1:0] step;
    } cmp_state_t;

    cmp_state_t s_q, s_d;
    logic       hit;

    assign hit = cmp_en_i && (count_i == s_q.cmp);

    always_comb begin
        s_d = s_q;
        if (wr_lo_i || wr_hi_i) begin
            if (wr_lo_i) s_d.cmp[HALF_W-1:0]     = wdata_i;
            if (wr_hi_i) s_d.cmp[CNT_W-1:HALF_W] = wdata_i;
        end else if (hit && auto_inc_i) begin
            s_d.cmp = s_q.cmp + CNT_W'(s_q.step);
        end
        if (wr_step_i) s_d.step = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cmp_o   = s_q.cmp;
    assign step_o  = s_q.step;
    assign match_o = hit;

    AST_CMP_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o && auto_inc_i && !wr_lo_i && !wr_hi_i)
        |=> (cmp_o == $past(cmp_o) + CNT_W'($past(step_o)))); // R9

    AST_CMP_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o && !auto_inc_i && !wr_lo_i && !wr_hi_i) |=> $stable(cmp_o)); // R8

    AST_CMP_SW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o && auto_inc_i && wr_lo_i)
        |=> (cmp_o[HALF_W-1:0] == $past(wdata_i))); // R10

endmodule

// File: rtl/frt_wstat.sv
module frt_wstat #(
    parameter int unsigned NUM = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] set_i,
    input  logic [NUM-1:0] clr_i,
    output logic [NUM-1:0] stat_o
);
    typedef struct packed {
        logic [NUM-1:0] pend;
        logic [NUM-1:0] stat;
    } ws_state_t;

    ws_state_t s_q, s_d;

    always_comb begin
        s_d      = s_q;
        s_d.pend = set_i;
        s_d.stat = (s_q.stat & ~clr_i) | s_q.pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign stat_o = s_q.stat;

    for (genvar gi = 0; gi < NUM; gi++) begin : g_flag_chk
        AST_WS_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            s_q.pend[gi] |=> stat_o[gi]); // R4
        AST_WS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_o[gi] && !clr_i[gi]) |=> stat_o[gi]); // R5
    end

endmodule

// File: rtl/frt_timer_top.sv
module frt_timer_top #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    input  logic              bus_we_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o
);
    import frt_pkg::*;

    localparam int unsigned CNT_W = 2 * DATA_W;

    localparam logic [ADDR_W-1:0] A_CNT_LO = ADDR_W'(OFF_CNT_LO);
    localparam logic [ADDR_W-1:0] A_CNT_HI = ADDR_W'(OFF_CNT_HI);
    localparam logic [ADDR_W-1:0] A_CNT_WS = ADDR_W'(OFF_CNT_WS);
    localparam logic [ADDR_W-1:0] A_CMP_LO = ADDR_W'(OFF_CMP_LO);
    localparam logic [ADDR_W-1:0] A_CMP_HI = ADDR_W'(OFF_CMP_HI);
    localparam logic [ADDR_W-1:0] A_STEP   = ADDR_W'(OFF_STEP);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_IRQ_ST = ADDR_W'(OFF_IRQ_ST);
    localparam logic [ADDR_W-1:0] A_IRQ_EN = ADDR_W'(OFF_IRQ_EN);
    localparam logic [ADDR_W-1:0] A_CMP_WS = ADDR_W'(OFF_CMP_WS);

    top_state_t s_q, s_d;

    logic wr_cnt_lo, wr_cnt_hi, wr_cnt_ws;
    logic wr_cmp_lo, wr_cmp_hi, wr_step, wr_ctrl;
    logic wr_irq_st, wr_irq_en, wr_cmp_ws;

    logic [CNT_W-1:0]   count;
    logic [CNT_W-1:0]   cmp_val;
    logic [DATA_W-1:0]  step_val;
    logic               match;

    logic [KWS_NUM-1:0] kws_set, kws_clr, kws_stat;
    logic [CWS_NUM-1:0] cws_set, cws_clr, cws_stat;

    // address decode
    always_comb begin
        wr_cnt_lo = bus_we_i && (bus_addr_i == A_CNT_LO);
        wr_cnt_hi = bus_we_i && (bus_addr_i == A_CNT_HI);
        wr_cnt_ws = bus_we_i && (bus_addr_i == A_CNT_WS);
        wr_cmp_lo = bus_we_i && (bus_addr_i == A_CMP_LO);
        wr_cmp_hi = bus_we_i && (bus_addr_i == A_CMP_HI);
        wr_step   = bus_we_i && (bus_addr_i == A_STEP);
        wr_ctrl   = bus_we_i && (bus_addr_i == A_CTRL);
        wr_irq_st = bus_we_i && (bus_addr_i == A_IRQ_ST);
        wr_irq_en = bus_we_i && (bus_addr_i == A_IRQ_EN);
        wr_cmp_ws = bus_we_i && (bus_addr_i == A_CMP_WS);
    end

    frt_counter #(.HALF_W(DATA_W)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (s_q.run),
        .wr_lo_i (wr_cnt_lo),
        .wr_hi_i (wr_cnt_hi),
        .wdata_i (bus_wdata_i),
        .count_o (count)
    );

    frt_comparator #(.HALF_W(DATA_W)) u_comparator (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_i    (count),
        .cmp_en_i   (s_q.cmp_en),
        .auto_inc_i (s_q.ainc),
        .wr_lo_i    (wr_cmp_lo),
        .wr_hi_i    (wr_cmp_hi),
        .wr_step_i  (wr_step),
        .wdata_i    (bus_wdata_i),
        .cmp_o      (cmp_val),
        .step_o     (step_val),
        .match_o    (match)
    );

    // write acknowledge flags
    always_comb begin
        kws_set = {wr_cnt_hi, wr_cnt_lo};
        kws_clr = wr_cnt_ws ? bus_wdata_i[KWS_NUM-1:0] : '0;

        cws_set = '0;
        cws_set[CWS_IDX_LO]   = wr_cmp_lo;
        cws_set[CWS_IDX_HI]   = wr_cmp_hi;
        cws_set[CWS_IDX_STEP] = wr_step;
        cws_set[CWS_IDX_CTRL] = wr_ctrl;

        cws_clr = '0;
        if (wr_cmp_ws) begin
            cws_clr[CWS_IDX_LO]   = bus_wdata_i[CWS_IDX_LO];
            cws_clr[CWS_IDX_HI]   = bus_wdata_i[CWS_IDX_HI];
            cws_clr[CWS_IDX_STEP] = bus_wdata_i[CWS_IDX_STEP];
            cws_clr[CWS_IDX_CTRL] = bus_wdata_i[CWS_CTRL_POS];
        end
    end

    frt_wstat #(.NUM(KWS_NUM)) u_cnt_wstat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (kws_set),
        .clr_i  (kws_clr),
        .stat_o (kws_stat)
    );

    frt_wstat #(.NUM(CWS_NUM)) u_cmp_wstat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (cws_set),
        .clr_i  (cws_clr),
        .stat_o (cws_stat)
    );

    // control and interrupt state
    always_comb begin
        s_d = s_q;
        if (wr_ctrl) begin
            s_d.run    = bus_wdata_i[CTRL_RUN_BIT];
            s_d.ainc   = bus_wdata_i[CTRL_AINC_BIT];
            s_d.cmp_en = bus_wdata_i[CTRL_CEN_BIT];
        end
        if (wr_irq_en) s_d.irq_en = bus_wdata_i[0];
        if (match)
            s_d.irq_st = 1'b1;
        else if (wr_irq_st && bus_wdata_i[0])
            s_d.irq_st = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // read mux
    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            A_CNT_LO: bus_rdata_o = count[DATA_W-1:0];
            A_CNT_HI: bus_rdata_o = count[CNT_W-1:DATA_W];
            A_CNT_WS: bus_rdata_o = DATA_W'(kws_stat);
            A_CMP_LO: bus_rdata_o = cmp_val[DATA_W-1:0];
            A_CMP_HI: bus_rdata_o = cmp_val[CNT_W-1:DATA_W];
            A_STEP:   bus_rdata_o = step_val;
            A_CTRL: begin
                bus_rdata_o[CTRL_RUN_BIT]  = s_q.run;
                bus_rdata_o[CTRL_AINC_BIT] = s_q.ainc;
                bus_rdata_o[CTRL_CEN_BIT]  = s_q.cmp_en;
            end
            A_IRQ_ST: bus_rdata_o = DATA_W'(s_q.irq_st);
            A_IRQ_EN: bus_rdata_o = DATA_W'(s_q.irq_en);
            A_CMP_WS: begin
                bus_rdata_o[CWS_IDX_LO]   = cws_stat[CWS_IDX_LO];
                bus_rdata_o[CWS_IDX_HI]   = cws_stat[CWS_IDX_HI];
                bus_rdata_o[CWS_IDX_STEP] = cws_stat[CWS_IDX_STEP];
                bus_rdata_o[CWS_CTRL_POS] = cws_stat[CWS_IDX_CTRL];
            end
            default: bus_rdata_o = '0;
        endcase
    end

    assign irq_o = s_q.irq_st & s_q.irq_en;

    AST_IRQ_ST_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> (bus_addr_i != A_IRQ_ST || bus_rdata_o[0])); // R6

    AST_IRQ_ST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!match && wr_irq_st && bus_wdata_i[0]) |=> !irq_o); // R6

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_irq_en && !s_q.irq_en) |=> (!irq_o || $past(match))); // R7

endmodule

// File: tb/frt_timer_top_bench.sv
`timescale 1ns/1ps
module frt_timer_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq;

    always #2 clk = ~clk;

    frt_timer_top u_frt_timer_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_we_i    (bus_we),
        .bus_rdata_o (bus_rdata),
        .irq_o       (irq)
    );

    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 0;
    string phase  = "R1";

    // reference model state
    longint unsigned m_cnt = 0, m_cmp = 0;
    bit [31:0] m_step = 0;
    bit m_run = 0, m_ainc = 0, m_cen = 0, m_ist = 0, m_ien = 0;
    bit [1:0]  m_kpend = 0, m_kws = 0;
    bit [31:0] m_cpend = 0, m_cws = 0;
    int        n_events = 0;

    function automatic bit m_irq();
        return m_ist & m_ien;
    endfunction

    function automatic bit [31:0] model_read(input bit [11:0] a);
        case (a)
            12'h100: return m_cnt[31:0];
            12'h104: return m_cnt[63:32];
            12'h110: return {30'd0, m_kws};
            12'h200: return m_cmp[31:0];
            12'h204: return m_cmp[63:32];
            12'h208: return m_step;
            12'h240: return (32'(m_run) << 8) | (32'(m_ainc) << 1) | 32'(m_cen);
            12'h244: return 32'(m_ist);
            12'h248: return 32'(m_ien);
            12'h24C: return m_cws;
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_tick();
        bit w;
        bit [11:0] a;
        bit [31:0] d;
        bit hit;
        longint unsigned n_cnt, n_cmp;
        bit [31:0] kclr, cclr;
        w = bus_we; a = bus_addr; d = bus_wdata;
        hit = m_cen && (m_cnt == m_cmp);
        n_cnt = m_cnt;
        if (w && a == 12'h100)      n_cnt[31:0]  = d;
        else if (w && a == 12'h104) n_cnt[63:32] = d;
        else if (m_run)             n_cnt = m_cnt + 1;
        n_cmp = m_cmp;
        if (w && a == 12'h200)      n_cmp[31:0]  = d;
        else if (w && a == 12'h204) n_cmp[63:32] = d;
        else if (hit && m_ainc)     n_cmp = m_cmp + longint'(m_step);
        if (w && a == 12'h208) m_step = d;
        if (hit) begin
            m_ist = 1; n_events++;
        end else if (w && a == 12'h244 && d[0]) m_ist = 0;
        if (w && a == 12'h248) m_ien = d[0];
        kclr = (w && a == 12'h110) ? d : 32'd0;
        cclr = (w && a == 12'h24C) ? (d & 32'h0001_0007) : 32'd0;
        m_kws = (m_kws & ~kclr[1:0]) | m_kpend;
        m_cws = (m_cws & ~cclr) | m_cpend;
        m_kpend = {w && a == 12'h104, w && a == 12'h100};
        m_cpend = 0;
        if (w && a == 12'h200) m_cpend[0]  = 1;
        if (w && a == 12'h204) m_cpend[1]  = 1;
        if (w && a == 12'h208) m_cpend[2]  = 1;
        if (w && a == 12'h240) m_cpend[16] = 1;
        if (w && a == 12'h240) begin
            m_run = d[8]; m_ainc = d[1]; m_cen = d[0];
        end
        m_cnt = n_cnt;
        m_cmp = n_cmp;
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_cmp = 0; m_step = 0;
            m_run = 0; m_ainc = 0; m_cen = 0; m_ist = 0; m_ien = 0;
            m_kpend = 0; m_kws = 0; m_cpend = 0; m_cws = 0;
        end else begin
            model_tick();
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h @%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_now();
        chk(phase, "rdata", bus_rdata, model_read(bus_addr));
        chk(phase, "irq", 32'(irq), 32'(m_irq()));
    endtask

    task automatic step(input logic [11:0] a, input logic [31:0] d, input logic w);
        @(negedge clk);
        compare_now();
        bus_addr = a; bus_wdata = d; bus_we = w;
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        step(a, 32'd0, 1'b0);
        #1;
        chk(tag, "readback", bus_rdata, exp);
    endtask

    task automatic set_cmp(input longint unsigned v);
        step(12'h204, v[63:32], 1'b1);
        step(12'h200, v[31:0], 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        longint unsigned v;
        // R1 reset state
        phase = "R1";
        step(12'h100, 0, 0);
        step(12'h240, 0, 0);
        step(12'h24C, 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        rd_chk("R1", 12'h100, 32'd0);
        rd_chk("R1", 12'h244, 32'd0);
        chk("R1", "irq after reset", 32'(irq), 32'd0);

        // R2 counting with carry into high half
        phase = "R2";
        step(12'h100, 32'hFFFF_FFF0, 1);
        step(12'h104, 32'h0000_0005, 1);
        step(12'h240, 32'h0000_0100, 1);
        for (int i = 0; i < 24; i++) step((i % 2) ? 12'h100 : 12'h104, 0, 0);
        rd_chk("R2", 12'h104, 32'h0000_0006);
        rd_chk("R11", 12'h240, 32'h0000_0100);

        // R4 counter write flags
        phase = "R4";
        rd_chk("R4", 12'h110, 32'h3);
        step(12'h110, 32'h1, 1);
        rd_chk("R4", 12'h110, 32'h2);
        step(12'h110, 32'h2, 1);
        rd_chk("R4", 12'h110, 32'h0);
        step(12'h100, 32'h0000_0200, 1);
        step(12'h110, 32'h1, 1);
        rd_chk("R4", 12'h110, 32'h1);
        step(12'h110, 32'h1, 1);

        // R3 single-half writes while running
        phase = "R3";
        step(12'h104, 32'h0000_00AA, 1);
        rd_chk("R3", 12'h104, 32'h0000_00AA);
        step(12'h100, 32'h0000_1000, 1);
        rd_chk("R3", 12'h100, 32'h0000_1000);
        rd_chk("R3", 12'h100, 32'h0000_1001);
        rd_chk("R3", 12'h104, 32'h0000_00AA);

        // R5 comparator-side write flags
        phase = "R5";
        step(12'h24C, 32'h0001_0007, 1);
        step(12'h204, 32'hFFFF_FFFF, 1);
        step(12'h200, 32'hFFFF_FFFF, 1);
        step(12'h208, 32'h0000_0009, 1);
        step(12'h240, 32'h0000_0100, 1);
        step(12'h24C, 0, 0);
        rd_chk("R5", 12'h24C, 32'h0001_0007);
        step(12'h24C, 32'h0001_0000, 1);
        rd_chk("R5", 12'h24C, 32'h0000_0007);
        step(12'h24C, 32'h0000_0007, 1);
        rd_chk("R5", 12'h24C, 32'h0);

        // R6 / R8 one-shot match
        phase = "R6";
        v = m_cnt + 40;
        set_cmp(v);
        step(12'h248, 32'h1, 1);
        step(12'h240, 32'h0000_0101, 1);
        for (int i = 0; i < 100 && !m_irq(); i++) step(12'h244, 0, 0);
        #1;
        chk("R7", "irq on enabled match", 32'(irq), 32'd1);
        step(12'h244, 32'h1, 1);
        rd_chk("R6", 12'h244, 32'd0);
        phase = "R8";
        for (int i = 0; i < 60; i++) step(12'h200, 0, 0);
        #1;
        chk("R8", "no second event", 32'(irq), 32'd0);
        rd_chk("R8", 12'h200, v[31:0]);

        // R7 masking
        phase = "R7";
        step(12'h248, 32'h0, 1);
        v = m_cnt + 30;
        set_cmp(v);
        for (int i = 0; i < 100 && !m_ist; i++) step(12'h244, 0, 0);
        #1;
        chk("R7", "irq masked", 32'(irq), 32'd0);
        rd_chk("R7", 12'h244, 32'd1);
        step(12'h248, 32'h1, 1);
        step(12'h248, 0, 0);
        #1;
        chk("R7", "irq unmasked", 32'(irq), 32'd1);
        step(12'h244, 32'h1, 1);

        // R9 periodic events
        phase = "R9";
        step(12'h208, 32'd12, 1);
        v = m_cnt + 30;
        set_cmp(v);
        n_events = 0;
        step(12'h240, 32'h0000_0103, 1);
        for (int i = 0; i < 130; i++) begin
            if (m_ist) step(12'h244, 32'h1, 1);
            else       step(12'h200, 0, 0);
        end
        chk("R9", "periodic event count", 32'(n_events >= 7), 32'd1);
        rd_chk("R11", 12'h240, 32'h0000_0103);

        // R10 software write on the match edge
        phase = "R10";
        for (int i = 0; i < 40 && !(m_cnt + 1 == m_cmp); i++) step(12'h200, 0, 0);
        step(12'h200, 32'h0000_0000, 1);
        rd_chk("R10", 12'h200, 32'h0000_0000);
        step(12'h244, 32'h1, 1);

        // R11 unmapped reads
        phase = "R11";
        rd_chk("R11", 12'h108, 32'd0);
        rd_chk("R11", 12'h300, 32'd0);
        rd_chk("R11", 12'hFFC, 32'd0);
        for (int i = 0; i < 4; i++) step(12'h100, 0, 0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule